// File: doc/BRIEF.md
# Two-Bit Serial Check Generator

This block computes a two-bit check value over a serial bit stream, one bit per strobe. The value covers a fixed span of 65 bits and starts from a zero seed at every word boundary. A transmitter feeds it the outgoing bits in order. Once the span is complete, the two check bits are held steady, so they can be shifted out straight after the data.

The recurrence is a small two-bit state machine, not a general polynomial. Call the state bits `h` (high) and `l` (low) and the incoming bit `d`. On each absorbed bit, `h` becomes `l ^ d` and `l` becomes `l ^ d ^ h`. Every data position feeds a nonzero pattern into the final value, so any single flipped bit changes the result.

The same block can be used on the receive side. After the span is complete, the received check bits are presented on a compare strobe. A registered mismatch flag then reports whether they differ from the value computed locally.

Top module: `twobit_serial_check`

## Requirements
- R1: On each absorbed bit, the next value of `chk_o[1]` equals the current `chk_o[0]` XOR the incoming bit `bit_i`.
- R2: On each absorbed bit, the next value of `chk_o[0]` equals the current `chk_o[0]` XOR `bit_i` XOR the current `chk_o[1]`.
- R3: Synchronous reset, or `word_clr_i` without `bit_vld_i`, sets `chk_o` to 2'b00 and `done_o` to 0 one cycle later.
- R4: `done_o` is 0 after 64 absorbed bits of a word and rises one cycle after the 65th absorbed bit, the bit with index 64.
- R5: While `done_o` is 1, further valid bits leave `chk_o` and `done_o` unchanged until the next clear.
- R6: A cycle without `bit_vld_i` leaves `chk_o` unchanged and absorbs no bit.
- R7: When `word_clr_i` and `bit_vld_i` are high together, the state reseeds to zero and that same bit is absorbed as bit 0, so `chk_o` becomes `{bit_i, bit_i}` and the word continues from index 1.
- R8: When `rx_chk_vld_i` is high while `done_o` is 1 and no clear is present, `mismatch_o` takes the value (`rx_chk_i` != `chk_o`) on the next cycle. A compare strobe before `done_o` is ignored. A clear sets `mismatch_o` to 0.
- R9: For a 65-bit word, the value of `chk_o` differs from that of a word which differs in exactly one bit position. Four reference values, with bits sent in index order 0 to 64: the all-zero word gives 2'b00; the all-one word gives 2'b01; a word with only bit 64 set gives 2'b11; a word with only bit 0 set gives 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_clr_i | input | 1 | Start of word: reseed to zero |
| bit_vld_i | input | 1 | Strobe: `bit_i` is valid this cycle |
| bit_i | input | 1 | Serial data bit |
| rx_chk_vld_i | input | 1 | Strobe: received check bits are valid |
| rx_chk_i | input | 2 | Received check bits for compare |
| chk_o | output | 2 | Computed check bits {high, low} |
| done_o | output | 1 | High once 65 bits have been absorbed |
| mismatch_o | output | 1 | Received check bits differed from computed value |

## Verification
Two functions can fall in the same cycle: the word-start clear and the absorption of a data bit. The bench first completes a word. It then raises `word_clr_i` and `bit_vld_i` together with a 1 bit, and expects `chk_o` to read 2'b11 with `done_o` low. It then sends 64 more zero bits and expects the word's final value to read 2'b10, which is the value for a lone bit at index 0. That result shows the coinciding bit was counted as bit 0 and not dropped or counted twice. The clear also coincides with a compare strobe, and the expected result is that the mismatch flag stays low.

// File: rtl/twobit_check_pkg.sv
package twobit_check_pkg;

    localparam int unsigned SPAN_DEFAULT = 65;

    typedef struct packed {
        logic hi;
        logic lo;
    } chk_pair_t;

    localparam chk_pair_t CHK_SEED = '{hi: 1'b0, lo: 1'b0};

    // One step of the two-bit recurrence.
    function automatic chk_pair_t chk_step(input chk_pair_t cur, input logic d);
        chk_pair_t nxt;
        nxt.hi = cur.lo ^ d;
        nxt.lo = (cur.lo ^ d) ^ cur.hi;
        return nxt;
    endfunction

endpackage

// File: rtl/chk_state_reg.sv
module chk_state_reg
    import twobit_check_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      seed_i,
    input  logic      take_i,
    input  logic      bit_i,
    output chk_pair_t state_o
);
    chk_pair_t state_q;
    chk_pair_t state_d;

    always_comb begin
        state_d = state_q;
        if (seed_i) begin
            state_d = take_i ? chk_step(CHK_SEED, bit_i) : CHK_SEED;
        end else if (take_i) begin
            state_d = chk_step(state_q, bit_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CHK_SEED;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/span_counter.sv
module span_counter #(
    parameter int unsigned SPAN = 65
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic adv_i,
    output logic full_o
);
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SPAN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                       cnt_d = adv_i ? CNT_W'(1) : '0;
        else if (adv_i && cnt_q != LAST) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign full_o = (cnt_q == LAST);
endmodule

// File: rtl/chk_compare.sv
module chk_compare
    import twobit_check_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr_i,
    input  logic      cmp_i,
    input  logic [1:0] rx_i,
    input  chk_pair_t calc_i,
    output logic      mismatch_o
);
    logic mis_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) mis_q <= 1'b0;
        else if (cmp_i)   mis_q <= (rx_i != {calc_i.hi, calc_i.lo});
    end

    assign mismatch_o = mis_q;
endmodule

// File: rtl/twobit_serial_check.sv
module twobit_serial_check
    import twobit_check_pkg::*;
#(
    parameter int unsigned SPAN       = SPAN_DEFAULT,
    parameter bit          HAS_RX_CMP = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       word_clr_i,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    input  logic       rx_chk_vld_i,
    input  logic [1:0] rx_chk_i,
    output logic [1:0] chk_o,
    output logic       done_o,
    output logic       mismatch_o
);
    chk_pair_t state;
    logic      full;
    logic      take;

    // A bit is absorbed when valid and the span is open; a clear always reopens it.
    assign take = bit_vld_i && (word_clr_i || !full);

    chk_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .seed_i  (word_clr_i),
        .take_i  (take),
        .bit_i   (bit_i),
        .state_o (state)
    );

    span_counter #(.SPAN(SPAN)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (word_clr_i),
        .adv_i  (bit_vld_i),
        .full_o (full)
    );

    generate
        if (HAS_RX_CMP) begin : g_cmp
            chk_compare u_cmp (
                .clk        (clk),
                .rst        (rst),
                .clr_i      (word_clr_i),
                .cmp_i      (rx_chk_vld_i && full),
                .rx_i       (rx_chk_i),
                .calc_i     (state),
                .mismatch_o (mismatch_o)
            );
        end else begin : g_nocmp
            logic unused_rx;
            assign unused_rx  = rx_chk_vld_i ^ ^rx_chk_i;
            assign mismatch_o = 1'b0;
        end
    endgenerate

    assign chk_o  = {state.hi, state.lo};
    assign done_o = full;
endmodule

// File: rtl/twobit_serial_check_sva.sv
module twobit_serial_check_sva
    import twobit_check_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       word_clr_i,
    input logic       bit_vld_i,
    input logic       bit_i,
    input logic       rx_chk_vld_i,
    input logic [1:0] rx_chk_i,
    input logic [1:0] chk_o,
    input logic       done_o,
    input logic       mismatch_o
);
    assert_step_hi_R1: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_i && !word_clr_i && !done_o) |=> chk_o[1] == ($past(chk_o[0]) ^ $past(bit_i)));

    assert_step_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_i && !word_clr_i && !done_o)
            |=> chk_o[0] == ($past(chk_o[0]) ^ $past(bit_i) ^ $past(chk_o[1])));

    assert_clear_seed_R3: assert property (@(posedge clk) disable iff (rst)
        (word_clr_i && !bit_vld_i) |=> (chk_o == 2'b00 && !done_o));

    assert_hold_after_span_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !word_clr_i) |=> ($stable(chk_o) && done_o));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld_i && !word_clr_i) |=> $stable(chk_o));

    assert_clear_absorb_R7: assert property (@(posedge clk) disable iff (rst)
        (word_clr_i && bit_vld_i) |=> (chk_o == {2{$past(bit_i)}} && !done_o));

    assert_compare_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_chk_vld_i && done_o && !word_clr_i) |=> mismatch_o == ($past(rx_chk_i) != $past(chk_o)));

    assert_clear_mismatch_R8: assert property (@(posedge clk) disable iff (rst)
        word_clr_i |=> !mismatch_o);
endmodule

bind twobit_serial_check twobit_serial_check_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .word_clr_i   (word_clr_i),
    .bit_vld_i    (bit_vld_i),
    .bit_i        (bit_i),
    .rx_chk_vld_i (rx_chk_vld_i),
    .rx_chk_i     (rx_chk_i),
    .chk_o        (chk_o),
    .done_o       (done_o),
    .mismatch_o   (mismatch_o)
);

// File: tb/twobit_serial_check_tb.sv
module twobit_serial_check_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_clr_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       rx_chk_vld_i = 1'b0;
    logic [1:0] rx_chk_i = 2'b00;
    logic [1:0] chk_o;
    logic       done_o;
    logic       mismatch_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    twobit_serial_check u_dut (
        .clk(clk), .rst(rst), .word_clr_i(word_clr_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .rx_chk_vld_i(rx_chk_vld_i), .rx_chk_i(rx_chk_i),
        .chk_o(chk_o), .done_o(done_o), .mismatch_o(mismatch_o)
    );

    // {word (bit n sent n-th), expected check}
    localparam int NVEC = 7;
    localparam logic [66:0] VECS [NVEC] = '{
        {65'h0,                 2'b00},
        {{65{1'b1}},            2'b01},
        {65'h1 << 64,           2'b11},
        {65'h1,                 2'b10},
        {65'h1 << 63,           2'b10},
        {65'h1 << 62,           2'b01},
        {(65'h1 << 64) | 65'h1, 2'b01}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic clear_word();
        @(negedge clk); word_clr_i = 1'b1; bit_vld_i = 1'b0;
        @(negedge clk); word_clr_i = 1'b0;
    endtask

    task automatic send_bits(input logic [64:0] w, input int from, input int to);
        for (int i = from; i <= to; i++) begin
            @(negedge clk); bit_vld_i = 1'b1; bit_i = w[i];
        end
        @(negedge clk); bit_vld_i = 1'b0; bit_i = 1'b0;
        #1;
    endtask

    task automatic compare(input logic [1:0] rx);
        @(negedge clk); rx_chk_vld_i = 1'b1; rx_chk_i = rx;
        @(negedge clk); rx_chk_vld_i = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(chk_o == 2'b00 && !done_o && !mismatch_o, "R3 reset state", int'(chk_o), 0);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            clear_word();
            send_bits(VECS[v][66:2], 0, 64);
            check(chk_o == VECS[v][1:0], $sformatf("R1 R2 R9 vector %0d", v),
                  int'(chk_o), int'(VECS[v][1:0]));
            check(done_o == 1'b1, $sformatf("R4 done vector %0d", v), int'(done_o), 1);
        end

        // R4: not done after 64 bits
        clear_word();
        check(chk_o == 2'b00 && !done_o, "R3 clear reseeds", int'(chk_o), 0);
        send_bits(65'h1 << 64, 0, 63);
        check(!done_o, "R4 not done after 64 bits", int'(done_o), 0);
        // R8: compare before done ignored
        compare(2'b11);
        check(!mismatch_o, "R8 early compare ignored", int'(mismatch_o), 0);
        // R6: idle cycles hold
        repeat (4) @(negedge clk);
        #1;
        check(chk_o == 2'b00 && !done_o, "R6 idle hold", int'(chk_o), 0);
        send_bits(65'h1 << 64, 64, 64);
        check(chk_o == 2'b11 && done_o, "R4 done after bit 64", int'(chk_o), 3);

        // R5: extra bits ignored
        send_bits({65{1'b1}}, 0, 2);
        check(chk_o == 2'b11 && done_o, "R5 extra bits ignored", int'(chk_o), 3);

        // R8: checker mode
        compare(2'b11);
        check(!mismatch_o, "R8 match", int'(mismatch_o), 0);
        compare(2'b10);
        check(mismatch_o, "R8 mismatch", int'(mismatch_o), 1);
        compare(2'b01);
        check(mismatch_o, "R8 mismatch again", int'(mismatch_o), 1);

        // R7: clear with valid bit; compare strobe in same cycle
        @(negedge clk);
        word_clr_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1; rx_chk_vld_i = 1'b1; rx_chk_i = 2'b00;
        @(negedge clk);
        word_clr_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0; rx_chk_vld_i = 1'b0;
        #1;
        check(chk_o == 2'b11 && !done_o, "R7 clear absorbs bit 0", int'(chk_o), 3);
        check(!mismatch_o, "R8 clear drops mismatch", int'(mismatch_o), 0);
        send_bits(65'h0, 1, 64);
        check(chk_o == 2'b10 && done_o, "R7 word continues from index 1", int'(chk_o), 2);

        // R9: single-bit flips differ from zero word
        check(VECS[0][1:0] != VECS[3][1:0], "R9 flip bit 0 detected", int'(VECS[3][1:0]), 0);

        // R3: synchronous reset mid-word
        clear_word();
        send_bits({65{1'b1}}, 0, 5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check(chk_o == 2'b00 && !done_o, "R3 reset mid-word", int'(chk_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule